// File: doc/BRIEF.md
# Compact I2C Bus Master

This block is a small I2C master meant to sit beside a tiny controller. The bus runs at a fixed 100 kbit/s, and the divider for that rate is worked out at elaboration from a system clock frequency parameter. The controller moves the bus one byte at a time. It pulses `go` with a byte and a flag that marks the byte as the last one of the frame. The first `go` on an idle bus makes the block issue a START and send that byte as the address. Bit 0 of the address byte (the R/W bit) fixes the direction of every later byte in the frame. In a read frame the value on `go_data` is ignored. When a byte marked last completes, the block issues a STOP.

Between the bytes of a frame the block holds SCL low and waits for the next command. Three values stay readable until a later transfer replaces them: the last byte sent, the last byte received and the bit seen in the ninth clock. A per-frame byte counter restarts at every START. The busy output can be suppressed with a mask input. SDA and SCL are open drain: an output-enable of 1 pulls the line low.

Top module: `i2c_lean_master`

## Requirements
- R1: After reset both output enables are 0 (lines released), `busy` is 0, `frame_cnt`, `wr_byte` and `rd_byte` are 0, and `ack_bit` is 1.
- R2: Every SCL bit period is 4·Q clock cycles, with SCL high for 2·Q of them, where Q = max(1, CLK_HZ / (4·BUS_HZ)).
- R3: A `go` on an idle bus produces exactly one START (SDA falls while SCL is high) and then sends `go_data` MSB first as the address byte. `frame_cnt` clears to 0 at that START.
- R4: If the address byte has bit 0 = 0, each later byte of the frame is sent from `go_data` and the slave receives it unchanged.
- R5: For every byte the master sends, SDA is released in the ninth clock and the sampled level is stored in `ack_bit` (0 = acknowledged).
- R6: If the address byte has bit 0 = 1, each later byte is received MSB first into `rd_byte`. In the ninth clock the master drives ACK (low) unless the byte was marked last, in which case it leaves NACK (released). `ack_bit` records that level.
- R7: A byte marked last is followed by exactly one STOP (SDA rises while SCL is high), after which both lines are released. Otherwise SCL stays low after the byte.
- R8: `frame_cnt` increases by exactly 1 at the end of each byte of the frame, the address byte included.
- R9: `wr_byte` holds the last byte sent, and a read byte does not change it. `rd_byte` holds the last byte received.
- R10: `busy` is 1 from the cycle after an accepted `go` until that byte (and any STOP) has finished. It reads 0 whenever `busy_hide` is 1.
- R11: A `go` given while `busy` is set has no effect: neither the byte nor the last flag is taken.
- R12: Outside START and STOP, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | One-cycle command pulse: move one byte |
| go_data | input | 8 | Address or write data; ignored for read bytes |
| go_last | input | 1 | Marks the byte as the last of the frame (STOP follows) |
| busy_hide | input | 1 | Forces the busy output to 0 |
| busy | output | 1 | Byte or bus condition in progress |
| frame_cnt | output | CNT_W | Bytes completed since the last START |
| wr_byte | output | 8 | Last byte sent |
| rd_byte | output | 8 | Last byte received |
| ack_bit | output | 1 | SDA level in the last ninth clock (0 = ACK) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The assertions assume that only this master and cooperating slaves use the bus and that no device stretches SCL. They also assume that `go` may arrive at any time, including while a byte is moving. The behavioural slave in the bench changes SDA only after SCL has fallen and releases the line before every STOP, which keeps the bus within those limits. The random frames mix matched and unmatched addresses, both directions and lengths of zero to three data bytes. Directed frames pulse `go` in the middle of a byte and toggle the busy mask.

// File: rtl/i2c_lean_pkg.sv
package i2c_lean_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_HOLD,
        ST_STOP
    } st_e;

    typedef struct packed {
        st_e        st;
        logic [1:0] ph;
        logic [3:0] bitn;
        logic [7:0] sh;
        logic [7:0] rsh;
        logic       dir;
        logic       first;
        logic       last;
        logic       scl_oe;
        logic       sda_oe;
        logic [7:0] wr_byte;
        logic [7:0] rd_byte;
        logic       ack;
    } core_t;

endpackage

// File: rtl/i2c_lean_qtick.sv
module i2c_lean_qtick #(
    parameter int QLEN = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QLEN > 1) ? $clog2(QLEN) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(QLEN - 1));
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_lean_fsm.sv
module i2c_lean_fsm
    import i2c_lean_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             go,
    input  logic [7:0]       go_data,
    input  logic             go_last,
    input  logic             sda_i,
    output logic             run,
    output st_e              st,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic [7:0]       wr_byte,
    output logic [7:0]       rd_byte,
    output logic             ack_bit,
    output logic [CNT_W-1:0] frame_cnt
);
    core_t            d, q;
    logic [CNT_W-1:0] fc_d, fc_q;
    logic             writing;
    logic             bit_oe;

    always_comb begin
        d       = q;
        fc_d    = fc_q;
        writing = q.first || !q.dir;
        if (q.bitn[3]) bit_oe = writing ? 1'b0 : ~q.last;
        else           bit_oe = writing ? ~q.sh[7] : 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (go) begin
                    d.st      = ST_START;
                    d.ph      = 2'd0;
                    d.bitn    = 4'd0;
                    d.sh      = go_data;
                    d.wr_byte = go_data;
                    d.dir     = go_data[0];
                    d.first   = 1'b1;
                    d.last    = go_last;
                    fc_d      = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    d.ph = q.ph + 2'd1;
                    if (q.ph == 2'd1) d.sda_oe = 1'b1;
                    if (q.ph == 2'd3) begin
                        d.st     = ST_BIT;
                        d.bitn   = 4'd0;
                        d.scl_oe = 1'b1;
                    end
                end
            end
            ST_BIT: begin
                if (tick) begin
                    d.ph = q.ph + 2'd1;
                    case (q.ph)
                        2'd0: d.sda_oe = bit_oe;
                        2'd1: d.scl_oe = 1'b0;
                        2'd2: begin
                            if (q.bitn[3]) d.ack = sda_i;
                            else           d.rsh = {q.rsh[6:0], sda_i};
                        end
                        default: begin
                            d.scl_oe = 1'b1;
                            if (!q.bitn[3]) begin
                                d.bitn = q.bitn + 4'd1;
                                d.sh   = {q.sh[6:0], 1'b0};
                            end else begin
                                fc_d    = fc_q + 1'b1;
                                d.first = 1'b0;
                                if (!writing) d.rd_byte = q.rsh;
                                d.st = q.last ? ST_STOP : ST_HOLD;
                            end
                        end
                    endcase
                end
            end
            ST_HOLD: begin
                if (go) begin
                    d.st   = ST_BIT;
                    d.ph   = 2'd0;
                    d.bitn = 4'd0;
                    d.last = go_last;
                    if (!q.dir) begin
                        d.sh      = go_data;
                        d.wr_byte = go_data;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    d.ph = q.ph + 2'd1;
                    case (q.ph)
                        2'd0:    d.sda_oe = 1'b1;
                        2'd1:    d.scl_oe = 1'b0;
                        2'd2:    d.sda_oe = 1'b0;
                        default: d.st     = ST_IDLE;
                    endcase
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.ack     <= 1'b1;
            fc_q      <= '0;
        end else begin
            q         <= d;
            fc_q      <= fc_d;
        end
    end

    assign run       = (q.st == ST_START) || (q.st == ST_BIT) || (q.st == ST_STOP);
    assign st        = q.st;
    assign scl_oe    = q.scl_oe;
    assign sda_oe    = q.sda_oe;
    assign wr_byte   = q.wr_byte;
    assign rd_byte   = q.rd_byte;
    assign ack_bit   = q.ack;
    assign frame_cnt = fc_q;
endmodule

// File: rtl/i2c_lean_master.sv
module i2c_lean_master
    import i2c_lean_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BUS_HZ = 100_000,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [7:0]       go_data,
    input  logic             go_last,
    input  logic             busy_hide,
    output logic             busy,
    output logic [CNT_W-1:0] frame_cnt,
    output logic [7:0]       wr_byte,
    output logic [7:0]       rd_byte,
    output logic             ack_bit,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             sda_i
);
    localparam int Q_RAW = CLK_HZ / (4 * BUS_HZ);
    localparam int QLEN  = (Q_RAW < 1) ? 1 : Q_RAW;

    logic core_run;
    logic core_tick;
    st_e  core_st;

    i2c_lean_qtick #(.QLEN(QLEN)) u_qtick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (core_run),
        .tick  (core_tick)
    );

    i2c_lean_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (core_tick),
        .go        (go),
        .go_data   (go_data),
        .go_last   (go_last),
        .sda_i     (sda_i),
        .run       (core_run),
        .st        (core_st),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .wr_byte   (wr_byte),
        .rd_byte   (rd_byte),
        .ack_bit   (ack_bit),
        .frame_cnt (frame_cnt)
    );

    assign busy = core_run & ~busy_hide;
endmodule

// File: rtl/i2c_lean_chk.sv
module i2c_lean_chk
    import i2c_lean_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic             busy,
    input logic             busy_raw,
    input st_e              st,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic [7:0]       wr_byte,
    input logic [CNT_W-1:0] frame_cnt
);
    // R1: an idle core leaves both lines released
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!scl_oe && !sda_oe));

    // R3: SDA falls under a high SCL only as the START condition
    p_start_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe) |-> (st == ST_START));

    // R7: SDA rises under a high SCL only as the STOP condition
    p_stop_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !scl_oe) |-> (st == ST_STOP));

    // R7: between bytes of a frame SCL is held low
    p_hold_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> scl_oe);

    // R8: the byte counter only steps by one or restarts at zero
    p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt != $past(frame_cnt)) |->
        ((frame_cnt == $past(frame_cnt) + 1'b1) || (frame_cnt == '0)));

    // R10: no busy indication while waiting for a command
    p_busy_waiting_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) || (st == ST_HOLD)) |-> !busy);

    // R11: a command during a transfer leaves the sent byte untouched
    p_go_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_raw && go) |=> $stable(wr_byte));

    // R12: during data bits SDA holds still while SCL is released
    p_sda_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_BIT) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));
endmodule

bind i2c_lean_master i2c_lean_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .busy      (busy),
    .busy_raw  (core_run),
    .st        (core_st),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .wr_byte   (wr_byte),
    .frame_cnt (frame_cnt)
);

// File: tb/i2c_lean_master_tb.sv
module i2c_lean_master_tb;
    localparam int CLK_HZ = 4_000_000;
    localparam int Q      = 10;
    localparam logic [6:0] SLV = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic [7:0] go_data = 8'h00;
    logic       go_last = 1'b0;
    logic       busy_hide = 1'b0;
    logic       busy;
    logic [7:0] frame_cnt;
    logic [7:0] wr_byte, rd_byte;
    logic       ack_bit, scl_oe, sda_oe;
    logic       s_oe = 1'b0;
    logic       scl_l, sda_l;

    assign scl_l = ~scl_oe;
    assign sda_l = ~(sda_oe | s_oe);

    always #2 clk = ~clk;

    i2c_lean_master #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .go(go), .go_data(go_data), .go_last(go_last),
        .busy_hide(busy_hide), .busy(busy), .frame_cnt(frame_cnt),
        .wr_byte(wr_byte), .rd_byte(rd_byte), .ack_bit(ack_bit),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_l)
    );

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    function automatic logic [7:0] exp_rd(int k);
        return 8'hA5 ^ 8'(k * 29);
    endfunction

    // behavioural slave
    int         n_start = 0, n_stop = 0, bitc = 0, kidx = 0;
    logic       ps = 1'b1, pd = 1'b1, in_addr = 1'b0, matched = 1'b0, rdir = 1'b0, ninth = 1'b1;
    logic [7:0] rx = 8'h00, tx = 8'h00, addr_rx = 8'h00, last_rx = 8'h00;
    int         last_rise = 0, period = 0, last_fall_rise = 0, high_len = 0;

    always @(negedge clk) begin
        logic cs, cd;
        cyc++;
        cs = scl_l;
        cd = sda_l;
        if (!rst_n) begin
            s_oe = 1'b0; bitc = 0; in_addr = 1'b0; matched = 1'b0;
        end else begin
            if (cs && ps && pd && !cd) begin
                n_start++; bitc = 0; in_addr = 1'b1; matched = 1'b0;
                rdir = 1'b0; s_oe = 1'b0; kidx = 0;
            end else if (cs && ps && !pd && cd) begin
                n_stop++; bitc = 0; in_addr = 1'b0; matched = 1'b0; s_oe = 1'b0;
            end else if (cs && !ps) begin
                period = cyc - last_rise;
                last_rise = cyc;
                if (bitc < 8) rx = {rx[6:0], cd};
                else          ninth = cd;
                bitc++;
            end else if (!cs && ps) begin
                high_len = cyc - last_rise;
                if (bitc == 8) begin
                    if (in_addr) begin
                        addr_rx = rx;
                        matched = (rx[7:1] == SLV);
                        rdir    = rx[0];
                        s_oe    = matched;
                    end else if (!rdir) begin
                        if (matched) begin
                            last_rx = rx;
                            s_oe    = 1'b1;
                        end
                    end else begin
                        s_oe = 1'b0;
                    end
                end else if (bitc == 9) begin
                    bitc = 0;
                    if (matched && rdir && (in_addr || !ninth)) begin
                        tx = exp_rd(kidx);
                        kidx++;
                        s_oe = ~tx[7];
                    end else begin
                        s_oe = 1'b0;
                    end
                    in_addr = 1'b0;
                end else if (matched && rdir && !in_addr && bitc >= 1 && bitc <= 7) begin
                    s_oe = ~tx[7 - bitc];
                end
            end
        end
        ps = cs;
        pd = cd;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [7:0] d, input logic l);
        @(negedge clk);
        go = 1'b1; go_data = d; go_last = l;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    logic [7:0] exp_wr = 8'h00;

    task automatic check_byte(input int i, input logic [7:0] d, input logic rd,
                              input logic l, input logic m, input logic [7:0] a);
        chk("R8 frame_cnt", 32'(frame_cnt), 32'(i + 1));
        chk("R2 bit period", 32'(period), 32'(4 * Q));
        chk("R2 SCL high", 32'(high_len), 32'(2 * Q));
        if (i == 0 || !rd) begin
            exp_wr = d;
            chk("R9 wr_byte", 32'(wr_byte), 32'(d));
            chk("R5 ack_bit", 32'(ack_bit), m ? 32'd0 : 32'd1);
            if (i == 0) chk("R3 address MSB first", 32'(addr_rx), 32'(d));
            else if (m) chk("R4 slave got byte", 32'(last_rx), 32'(d));
        end else begin
            chk("R6 rd_byte", 32'(rd_byte), m ? 32'(exp_rd(i - 1)) : 32'hFF);
            chk("R6 master ack", 32'(ack_bit), l ? 32'd1 : 32'd0);
            chk("R9 wr_byte kept", 32'(wr_byte), 32'(a));
        end
        if (!l) chk("R7 SCL held low", 32'(scl_oe), 32'd1);
    endtask

    task automatic run_frame(input logic [6:0] a7, input logic rd, input int n);
        logic [7:0] a, d;
        logic m;
        a = {a7, rd};
        m = (a7 == SLV);
        n_start = 0;
        n_stop = 0;
        for (int i = 0; i <= n; i++) begin
            d = (i == 0) ? a : 8'($urandom);
            pulse(d, i == n);
            wait_idle();
            check_byte(i, d, rd, i == n, m, a);
        end
        chk("R3 one START", 32'(n_start), 32'd1);
        chk("R7 one STOP", 32'(n_stop), 32'd1);
        chk("R7 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
    endtask

    initial begin
        int seed;
        int r;
        seed = $urandom(32'd1234);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 lines", {30'd0, scl_oe, sda_oe}, 32'd0);
        chk("R1 frame_cnt", 32'(frame_cnt), 32'd0);
        chk("R1 bytes", {16'd0, wr_byte, rd_byte}, 32'd0);
        chk("R1 ack_bit", 32'(ack_bit), 32'd1);

        // directed: address only, then a read of three bytes
        run_frame(SLV, 1'b0, 0);
        run_frame(SLV, 1'b1, 3);

        // directed: busy mask and ignored command (R10, R11)
        n_start = 0; n_stop = 0;
        pulse({SLV, 1'b0}, 1'b0);
        repeat (3) @(negedge clk);
        chk("R10 busy during byte", 32'(busy), 32'd1);
        busy_hide = 1'b1;
        @(negedge clk);
        chk("R10 busy masked", 32'(busy), 32'd0);
        busy_hide = 1'b0;
        @(negedge clk);
        chk("R10 busy unmasked", 32'(busy), 32'd1);
        wait_idle();
        chk("R3 counter at START", 32'(frame_cnt), 32'd1);
        pulse(8'h5E, 1'b0);
        repeat (30) @(negedge clk);
        pulse(8'h3C, 1'b1);
        wait_idle();
        chk("R11 byte kept", 32'(wr_byte), 32'h5E);
        chk("R11 no STOP", 32'(scl_oe), 32'd1);
        chk("R11 count", 32'(frame_cnt), 32'd2);
        chk("R4 slave byte", 32'(last_rx), 32'h5E);
        pulse(8'h81, 1'b1);
        wait_idle();
        chk("R7 STOP after last", 32'(n_stop), 32'd1);
        chk("R8 three bytes", 32'(frame_cnt), 32'd3);

        // random frames
        for (int f = 0; f < 24; f++) begin
            r = int'($urandom);
            run_frame((r % 5 == 0) ? 7'h11 : SLV, r[3], (r >> 4) % 4);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        wait (cyc > 190000);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%0d expected<190000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule